// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O with Activity-LED Override

This block gives software five general-purpose pins. Each pin has its own direction bit and data bit. A pin set as output drives the stored data bit onto its pad, with the output enable asserted. A pin set as input leaves its pad undriven. The value seen at an input pad reaches the data register through a two-flop synchronizer. A small register port selects one of two 8-bit registers with a single address bit: the data register at address 0 and the control register at address 1. Writes take effect at the clock edge. Reads are combinational from the stored state.

Pin 0 has one extra role. When the LED-enable bit in the control register is set, pin 0 drives a live "bus connected" status input instead of its data bit. Pin 0's output enable is forced on at the same time, so an activity LED lights whatever the pin's direction bit says. Two conditions block the override, and either one is enough: a second control bit (the LED-block bit) being set, or an external flag that reports a configuration autoload in progress. While the override is blocked, pin 0 is an ordinary GPIO pin again.

Top module: `gpio_led_ctrl`

## Requirements
- R1: After reset the control register reads 0x0F: pins 3..0 are inputs, pin 4 is an output, and the LED-enable and LED-block bits are 0. The data register holds 0, so gpio_out is 0 and gpio_oe is 5'b10000.
- R2: Control register bits [4:0] are the per-pin direction bits, with 1 meaning input and 0 meaning output. For each pin whose override is not active, gpio_oe[i] is the inverse of direction bit i.
- R3: A write to the data register (address 0) stores wdata[4:0]. gpio_out[i] equals stored data bit i for every pin whose override is not active.
- R4: A read of the data register returns the synchronized pad value for input pins and the stored bit for output pins. A pad change shows in the read value after exactly two rising clock edges. Read bits [7:5] are 0.
- R5: When control bit 5 (LED enable) is 1, control bit 6 (LED block) is 0 and autoload_busy is 0, gpio_out[0] follows link_stat and gpio_oe[0] is 1. This holds regardless of data bit 0 and direction bit 0.
- R6: Setting control bit 6 disables the override, and pin 0 returns to normal GPIO behaviour.
- R7: While autoload_busy is 1, the override is disabled and pin 0 returns to normal GPIO behaviour.
- R8: The override does not change pins 4..1 or the stored data bits. The data register read-back is unaffected by it.
- R9: Control register bit 7 ignores writes and always reads 0. A control read returns {0, LED block, LED enable, direction[4:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| gpio_in | input | 5 | Pad input values |
| gpio_out | output | 5 | Pad output values |
| gpio_oe | output | 5 | Pad output enables |
| link_stat | input | 1 | Live bus-connected status for the activity LED |
| autoload_busy | input | 1 | High while a configuration autoload is running |

## Verification
The latency property on input read-back assumes gpio_in changes only away from clock edges. The stimulus changes it only on falling edges. That property also needs two clean edges since reset before it applies, and the checker counts those edges itself. The override properties treat link_stat and autoload_busy as ordinary synchronous inputs. The bench changes them only on falling edges, and it reads the register port while reg_wr is low, so every sampled read reflects state already settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_W      = 5;
    localparam int REG_W       = 8;
    localparam int LED_EN_BIT  = 5;
    localparam int LED_BLK_BIT = 6;
    localparam logic [GPIO_W-1:0] DIR_RST = 5'b01111;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTL  = 1'b1;

    typedef struct packed {
        logic              led_blk;
        logic              led_en;
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] dout;
    } regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [GPIO_W-1:0] pin_sync,
    output regs_t             regs_q,
    output logic [REG_W-1:0]  reg_rdata
);
    regs_t regs_d;
    logic  unused_wtop;

    assign unused_wtop = reg_wdata[REG_W-1];

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            if (reg_addr == ADDR_CTL) begin
                regs_d.dir     = reg_wdata[GPIO_W-1:0];
                regs_d.led_en  = reg_wdata[LED_EN_BIT];
                regs_d.led_blk = reg_wdata[LED_BLK_BIT];
            end else begin
                regs_d.dout    = reg_wdata[GPIO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dout    <= '0;
            regs_q.dir     <= DIR_RST;
            regs_q.led_en  <= 1'b0;
            regs_q.led_blk <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (reg_addr == ADDR_CTL)
            reg_rdata = {1'b0, regs_q.led_blk, regs_q.led_en, regs_q.dir};
        else
            reg_rdata = {{(REG_W-GPIO_W){1'b0}},
                         (regs_q.dir & pin_sync) | (~regs_q.dir & regs_q.dout)};
    end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
(
    input  regs_t             regs,
    input  logic              link_stat,
    input  logic              autoload_busy,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe
);
    logic led_live;

    assign led_live = regs.led_en & ~regs.led_blk & ~autoload_busy;

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        if (i == 0) begin : g_led
            assign pin_out[i] = led_live ? link_stat : regs.dout[i];
            assign pin_oe[i]  = led_live | ~regs.dir[i];
        end else begin : g_plain
            assign pin_out[i] = regs.dout[i];
            assign pin_oe[i]  = ~regs.dir[i];
        end
    end
endmodule

// File: rtl/gpio_led_ctrl.sv
module gpio_led_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe,
    input  logic              link_stat,
    input  logic              autoload_busy
);
    logic [GPIO_W-1:0] pin_sync;
    regs_t             regs_q;

    gpio_sync #(.W(GPIO_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gpio_in),
        .sync_out (pin_sync)
    );

    gpio_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .regs_q    (regs_q),
        .reg_rdata (reg_rdata)
    );

    gpio_pin_drive u_drive (
        .regs          (regs_q),
        .link_stat     (link_stat),
        .autoload_busy (autoload_busy),
        .pin_out       (gpio_out),
        .pin_oe        (gpio_oe)
    );
endmodule

// File: rtl/gpio_led_ctrl_chk.sv
module gpio_led_ctrl_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [GPIO_W-1:0] gpio_in,
    input logic [GPIO_W-1:0] gpio_out,
    input logic [GPIO_W-1:0] gpio_oe,
    input logic              link_stat,
    input logic              autoload_busy,
    input regs_t             regs_q
);
    logic [1:0] age_q;
    logic       unused_chk;

    assign unused_chk = reg_wdata[REG_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_LED_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.led_en && !regs_q.led_blk && !autoload_busy)
        |-> (gpio_oe[0] && gpio_out[0] == link_stat)); // R5

    AST_LED_BLK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.led_blk
        |-> (gpio_out[0] == regs_q.dout[0] && gpio_oe[0] == !regs_q.dir[0])); // R6

    AST_LED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        autoload_busy
        |-> (gpio_out[0] == regs_q.dout[0] && gpio_oe[0] == !regs_q.dir[0])); // R7

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTL)
        |=> ({regs_q.led_blk, regs_q.led_en, regs_q.dir} == $past(reg_wdata[REG_W-2:0]))); // R2

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $stable(regs_q))
        |-> ($stable(gpio_out[GPIO_W-1:1]) && $stable(gpio_oe[GPIO_W-1:1]))); // R8

    AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && reg_addr == ADDR_DATA)
        |-> ((reg_rdata[GPIO_W-1:0] & regs_q.dir) == ($past(gpio_in, 2) & regs_q.dir))); // R4

    AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTL) |-> (reg_rdata[REG_W-1] == 1'b0)); // R9
endmodule

bind gpio_led_ctrl gpio_led_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .gpio_in       (gpio_in),
    .gpio_out      (gpio_out),
    .gpio_oe       (gpio_oe),
    .link_stat     (link_stat),
    .autoload_busy (autoload_busy),
    .regs_q        (regs_q)
);

// File: tb/gpio_led_ctrl_test.sv
module gpio_led_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] gpio_in = '0;
    logic [4:0] gpio_out;
    logic [4:0] gpio_oe;
    logic       link_stat = 1'b0;
    logic       autoload_busy = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int         kind;   // 0 read data, 1 pad out, 2 pad oe
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    gpio_led_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .gpio_in       (gpio_in),
        .gpio_out      (gpio_out),
        .gpio_oe       (gpio_oe),
        .link_stat     (link_stat),
        .autoload_busy (autoload_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: settles 1 time unit after the falling edge, then scores
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sb.pop_front();
                case (it.kind)
                    0:       got = reg_rdata;
                    1:       got = {3'b000, gpio_out};
                    default: got = {3'b000, gpio_oe};
                endcase
                n_vec++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d got=%h exp=%h", it.tag, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic a, input logic [7:0] e, input string t);
        reg_addr = a;
        sb.push_back('{0, e, t});
    endtask

    task automatic expect_pad(input int k, input logic [7:0] e, input string t);
        sb.push_back('{k, e, t});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        expect_rd(1'b1, 8'h0F, "R1 ctl reset");
        expect_pad(1, 8'h00, "R1 out reset");
        expect_pad(2, 8'h10, "R1 oe reset");
        step();
        expect_rd(1'b0, 8'h00, "R1 data reset");

        // R4 synchronizer latency; pin 4 is output so its pad is ignored
        step();
        gpio_in = 5'b11010;
        step();
        expect_rd(1'b0, 8'h00, "R4 one edge not yet");
        step();
        expect_rd(1'b0, 8'h0A, "R4 two edges");

        // R3 and R4: write data, bits 7:5 dropped
        wr(1'b0, 8'hFF);
        expect_pad(1, 8'h1F, "R3 out after write");
        expect_rd(1'b0, 8'h1A, "R4 mixed read");

        // R2 all outputs
        wr(1'b1, 8'h00);
        expect_pad(2, 8'h1F, "R2 oe all out");
        expect_rd(1'b0, 8'h1F, "R4 outputs read stored");
        step();
        expect_rd(1'b1, 8'h00, "R2 ctl read");

        // R9 bit 7 ignored
        wr(1'b1, 8'h85);
        expect_rd(1'b1, 8'h05, "R9 bit7 dropped");
        expect_pad(2, 8'h1A, "R2 oe pattern");

        // R5 override
        wr(1'b0, 8'h1E);
        wr(1'b1, 8'h20);
        link_stat = 1'b1;
        step();
        expect_pad(1, 8'h1F, "R5 link high");
        expect_pad(2, 8'h1F, "R5 oe");
        step();
        link_stat = 1'b0;
        step();
        expect_pad(1, 8'h1E, "R5 link low");
        expect_rd(1'b0, 8'h1E, "R8 data untouched");
        wr(1'b1, 8'h21);
        link_stat = 1'b1;
        step();
        expect_pad(2, 8'h1F, "R5 oe forced over input dir");
        expect_pad(1, 8'h1F, "R5 out forced");

        // R6 block bit
        wr(1'b1, 8'h61);
        expect_pad(2, 8'h1E, "R6 oe normal");
        expect_pad(1, 8'h1E, "R6 out normal");

        // R7 busy
        wr(1'b1, 8'h20);
        autoload_busy = 1'b1;
        step();
        expect_pad(1, 8'h1E, "R7 busy blocks");
        expect_pad(2, 8'h1F, "R7 oe from dir");
        step();
        autoload_busy = 1'b0;
        step();
        expect_pad(1, 8'h1F, "R7 busy released");

        // R8 upper pins follow data during override
        wr(1'b0, 8'h0A);
        expect_pad(1, 8'h0B, "R8 upper pins");
        expect_rd(1'b0, 8'h0A, "R8 readback");

        step();
        step();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog got=%0d exp=%0d", cyc, WATCHDOG);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule